// File: doc/BRIEF.md
# NAND Command and Address Sequencer

This block converts one operation request into the series of bus cycles a raw NAND flash device expects. A request names an opcode. It may also carry a column address, a page (row) address, or both. The sequencer takes chip enable low, strobes each command byte with CLE and each address byte with ALE, and drives the byte on the I/O bus for one write-enable pulse. It works with small-page (512-byte) and large-page (2048-byte) devices and with 8-bit or 16-bit buses. The command or address bytes that the device needs besides the opcode are added automatically.

Once the last byte has been strobed, the block decides how the operation ends. It can finish at once. It can pulse `wait_start` to a separate ready-wait engine and hold until that engine answers on `wait_done`. If the board has no ready/busy pin, it counts out a fixed chip delay. It can also count out the change-column setup time after a random data-in or data-out command. Configuration is sampled when the request is accepted. Requests that arrive while the block is busy are dropped.

Top module: `nand_cmd_seq`

## Requirements
- R1: Every bus cycle moves one byte. WE# is low for WE_LOW_TICKS clocks and then high for WE_HIGH_TICKS clocks. CLE is high for a command byte and ALE is high for an address byte, never both at once. CLE, ALE and I/O stay constant while WE# is low. Multi-byte addresses go out low byte first.
- R2: When `req_col_en` is 0, no column byte is sent. When `req_row_en` is 0, no row byte is sent.
- R3: A row address uses bits 7:0 and then bits 15:8. When `cfg_row3` is 1, a third byte with bits 23:16 follows.
- R4: In large-page mode the column uses two bytes. In small-page mode it uses one byte. The 8-bit-only opcodes 0x90, 0xEC, 0xEE and 0xEF always get a single column byte.
- R5: When `cfg_bus16` is 1, the column is shifted right by one before it is sent, except for 8-bit-only opcodes. I/O bits 15:8 are 0 on every command and address cycle.
- R6: In large-page mode, opcode 0x50 is sent as 0x00 with the column increased by LP_PAGE_BYTES. A 0x00 that carries any address is followed by command 0x30 and a ready wait.
- R7: Opcode 0x00 with neither address emits only its command byte. It gets no 0x30 and no wait.
- R8: In large-page mode, 0x05 is followed by command 0xE0 and then a setup delay. 0x85 is followed only by the setup delay. The delay is `cfg_tccs_ticks` clocks, or TCCS_DEFAULT_NS rounded up to whole clocks (63 by default) when `cfg_tccs_ticks` is 0.
- R9: In small-page mode, 0x80 is preceded by a pointer command chosen from the column. A column at or above SP_PAGE_BYTES gives 0x50, with SP_PAGE_BYTES subtracted. A column from 256 up to SP_PAGE_BYTES gives 0x01, with 256 subtracted. Any other column, or no column, gives 0x00.
- R10: Opcodes 0x10, 0x15, 0x60, 0xD0, 0x80, 0x70, 0x90 and 0xEF finish with no wait. Other opcodes wait for ready. With `cfg_has_rb` set, the block gives a one-clock `wait_start` and holds until `wait_done`. With it clear, the block counts CHIP_DELAY_TICKS clocks.
- R11: CE# is low from acceptance until the clock after the one-clock `seq_done`. A `req_valid` seen while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a sequence (taken only when idle) |
| req_opcode | input | 8 | Command opcode |
| req_col | input | 16 | Column address |
| req_col_en | input | 1 | Column address present |
| req_row | input | 24 | Page (row) address |
| req_row_en | input | 1 | Row address present |
| cfg_large_page | input | 1 | 1 = large-page device, 0 = small-page device |
| cfg_bus16 | input | 1 | 16-bit device bus |
| cfg_row3 | input | 1 | Three row address bytes |
| cfg_has_rb | input | 1 | Ready/busy pin is wired to the wait engine |
| cfg_tccs_ticks | input | 8 | Setup delay in clocks, 0 = default |
| wait_done | input | 1 | Ready-wait engine reports device ready |
| busy | output | 1 | Sequence in progress |
| seq_done | output | 1 | One-clock pulse at the end of a sequence |
| wait_start | output | 1 | One-clock pulse to start the ready-wait engine |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write enable, active low |
| nand_io_out | output | 16 | I/O bus drive value |
| nand_io_oe | output | 1 | I/O bus output enable |

## Verification
Each request's byte stream is compared with a list the bench writes down by hand, so any wrong choice is caught at the pins:
- A wrong small-page pointer choice or a missing subtraction shows up as a bad leading command or column byte.
- A 16-bit halving applied to an 8-bit-only opcode shows up as a wrong column byte.
- A missing column offset in the out-of-band rewrite shows up as a wrong column byte.
- A dropped 0x30 or 0xE0 confirm shows up as a missing command byte.

The gap from the last WE# rise to `seq_done` is measured in clocks. That gap shows whether the right ending was taken: no wait, a handshake with the wait engine, the chip delay, the programmed setup delay, or the 63-clock default. The bench also fires a second request in the middle of a sequence; a design that accepted it would emit bytes the list does not contain.

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq #(
  parameter int WE_LOW_TICKS     = 2,
  parameter int WE_HIGH_TICKS    = 2,
  parameter int CHIP_DELAY_TICKS = 2500,
  parameter int CLK_PERIOD_NS    = 8,
  parameter int TCCS_DEFAULT_NS  = 500,
  parameter int SP_PAGE_BYTES    = 512,
  parameter int LP_PAGE_BYTES    = 2048
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [7:0]  req_opcode,
  input  logic [15:0] req_col,
  input  logic        req_col_en,
  input  logic [23:0] req_row,
  input  logic        req_row_en,
  input  logic        cfg_large_page,
  input  logic        cfg_bus16,
  input  logic        cfg_row3,
  input  logic        cfg_has_rb,
  input  logic [7:0]  cfg_tccs_ticks,
  input  logic        wait_done,
  output logic        busy,
  output logic        seq_done,
  output logic        wait_start,
  output logic        nand_ce_n,
  output logic        nand_cle,
  output logic        nand_ale,
  output logic        nand_we_n,
  output logic [15:0] nand_io_out,
  output logic        nand_io_oe
);
  localparam int TCCS_DEFAULT_TICKS = (TCCS_DEFAULT_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int SLOTS   = 8;
  localparam int IDX_W   = $clog2(SLOTS);
  localparam int MAX_A   = (CHIP_DELAY_TICKS > TCCS_DEFAULT_TICKS) ? CHIP_DELAY_TICKS : TCCS_DEFAULT_TICKS;
  localparam int MAX_B   = (WE_LOW_TICKS > WE_HIGH_TICKS) ? WE_LOW_TICKS : WE_HIGH_TICKS;
  localparam int MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_MAX = (MAX_C > 256) ? MAX_C : 256;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  localparam logic [7:0] OP_READ0   = 8'h00;
  localparam logic [7:0] OP_READ1   = 8'h01;
  localparam logic [7:0] OP_READOOB = 8'h50;
  localparam logic [7:0] OP_RSTART  = 8'h30;
  localparam logic [7:0] OP_RNDOUT  = 8'h05;
  localparam logic [7:0] OP_RNDOST  = 8'hE0;
  localparam logic [7:0] OP_RNDIN   = 8'h85;
  localparam logic [7:0] OP_SEQIN   = 8'h80;
  localparam logic [7:0] OP_PROG    = 8'h10;
  localparam logic [7:0] OP_CPROG   = 8'h15;
  localparam logic [7:0] OP_ERASE1  = 8'h60;
  localparam logic [7:0] OP_ERASE2  = 8'hD0;
  localparam logic [7:0] OP_STATUS  = 8'h70;
  localparam logic [7:0] OP_READID  = 8'h90;
  localparam logic [7:0] OP_PARAM   = 8'hEC;
  localparam logic [7:0] OP_GETFEAT = 8'hEE;
  localparam logic [7:0] OP_SETFEAT = 8'hEF;

  typedef enum logic [2:0] {S_IDLE, S_BUS, S_RBS, S_RBW, S_DLY, S_FIN} state_t;
  typedef enum logic [1:0] {P_NONE, P_READY, P_SETUP} post_t;
  typedef enum logic [1:0] {E_NONE, E_RB, E_DLY} end_t;

  state_t state_q;
  end_t   end_q;
  logic   phase_hi_q;
  logic [CNT_W-1:0] cnt_q, dly_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W:0]   len_q;
  logic [8:0]       slot_q [SLOTS];

  logic [8:0]       plan_slot [SLOTS];
  logic [IDX_W:0]   plan_len;
  post_t            plan_post;
  logic [7:0]       op_eff, ptr_op;
  logic [15:0]      col_eff, col_out;
  logic             eight_bit, no_wait_op, bare;

  always_comb begin
    for (int i = 0; i < SLOTS; i++) plan_slot[i] = '0;
    plan_len  = '0;
    plan_post = P_READY;
    op_eff    = req_opcode;
    col_eff   = req_col;
    ptr_op    = OP_READ0;
    if (cfg_large_page && req_opcode == OP_READOOB) begin
      op_eff  = OP_READ0;
      col_eff = req_col + 16'(LP_PAGE_BYTES);
    end
    if (!cfg_large_page && req_opcode == OP_SEQIN) begin
      if (req_col_en && req_col >= 16'(SP_PAGE_BYTES)) begin
        ptr_op  = OP_READOOB;
        col_eff = req_col - 16'(SP_PAGE_BYTES);
      end else if (req_col_en && req_col >= 16'd256) begin
        ptr_op  = OP_READ1;
        col_eff = req_col - 16'd256;
      end
      plan_slot[plan_len[IDX_W-1:0]] = {1'b1, ptr_op};
      plan_len = plan_len + 1'b1;
    end
    eight_bit = op_eff inside {OP_READID, OP_PARAM, OP_GETFEAT, OP_SETFEAT};
    col_out   = (cfg_bus16 && !eight_bit) ? (col_eff >> 1) : col_eff;
    plan_slot[plan_len[IDX_W-1:0]] = {1'b1, op_eff};
    plan_len = plan_len + 1'b1;
    if (req_col_en) begin
      plan_slot[plan_len[IDX_W-1:0]] = {1'b0, col_out[7:0]};
      plan_len = plan_len + 1'b1;
      if (cfg_large_page && !eight_bit) begin
        plan_slot[plan_len[IDX_W-1:0]] = {1'b0, col_out[15:8]};
        plan_len = plan_len + 1'b1;
      end
    end
    if (req_row_en) begin
      plan_slot[plan_len[IDX_W-1:0]] = {1'b0, req_row[7:0]};
      plan_len = plan_len + 1'b1;
      plan_slot[plan_len[IDX_W-1:0]] = {1'b0, req_row[15:8]};
      plan_len = plan_len + 1'b1;
      if (cfg_row3) begin
        plan_slot[plan_len[IDX_W-1:0]] = {1'b0, req_row[23:16]};
        plan_len = plan_len + 1'b1;
      end
    end
    bare       = !req_col_en && !req_row_en;
    no_wait_op = op_eff inside {OP_PROG, OP_CPROG, OP_ERASE1, OP_ERASE2,
                                OP_SEQIN, OP_STATUS, OP_READID, OP_SETFEAT};
    if (no_wait_op || (op_eff == OP_READ0 && bare)) begin
      plan_post = P_NONE;
    end else if (cfg_large_page && op_eff == OP_READ0) begin
      plan_slot[plan_len[IDX_W-1:0]] = {1'b1, OP_RSTART};
      plan_len = plan_len + 1'b1;
    end else if (cfg_large_page && op_eff == OP_RNDOUT) begin
      plan_slot[plan_len[IDX_W-1:0]] = {1'b1, OP_RNDOST};
      plan_len  = plan_len + 1'b1;
      plan_post = P_SETUP;
    end else if (cfg_large_page && op_eff == OP_RNDIN) begin
      plan_post = P_SETUP;
    end
  end

  logic [8:0] cur;
  assign cur = slot_q[idx_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      end_q      <= E_NONE;
      phase_hi_q <= 1'b0;
      cnt_q      <= '0;
      dly_q      <= '0;
      idx_q      <= '0;
      len_q      <= '0;
      for (int i = 0; i < SLOTS; i++) slot_q[i] <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (req_valid) begin
          for (int i = 0; i < SLOTS; i++) slot_q[i] <= plan_slot[i];
          len_q      <= plan_len;
          idx_q      <= '0;
          cnt_q      <= '0;
          phase_hi_q <= 1'b0;
          state_q    <= S_BUS;
          case (plan_post)
            P_NONE:  begin end_q <= E_NONE; dly_q <= '0; end
            P_READY: begin
              end_q <= cfg_has_rb ? E_RB : E_DLY;
              dly_q <= CNT_W'(CHIP_DELAY_TICKS);
            end
            default: begin
              end_q <= E_DLY;
              dly_q <= (cfg_tccs_ticks == 8'd0) ? CNT_W'(TCCS_DEFAULT_TICKS) : CNT_W'(cfg_tccs_ticks);
            end
          endcase
        end
        S_BUS: begin
          if (!phase_hi_q) begin
            if (cnt_q == CNT_W'(WE_LOW_TICKS - 1)) begin
              phase_hi_q <= 1'b1;
              cnt_q      <= '0;
            end else cnt_q <= cnt_q + 1'b1;
          end else if (cnt_q == CNT_W'(WE_HIGH_TICKS - 1)) begin
            cnt_q      <= '0;
            phase_hi_q <= 1'b0;
            if ({1'b0, idx_q} == len_q - 1'b1) begin
              case (end_q)
                E_RB:    state_q <= S_RBS;
                E_DLY:   state_q <= S_DLY;
                default: state_q <= S_FIN;
              endcase
            end else idx_q <= idx_q + 1'b1;
          end else cnt_q <= cnt_q + 1'b1;
        end
        S_RBS: state_q <= S_RBW;
        S_RBW: if (wait_done) state_q <= S_FIN;
        S_DLY: begin
          if (cnt_q == dly_q - 1'b1) begin
            cnt_q   <= '0;
            state_q <= S_FIN;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy        = state_q != S_IDLE;
  assign seq_done    = state_q == S_FIN;
  assign wait_start  = state_q == S_RBS;
  assign nand_ce_n   = state_q == S_IDLE;
  assign nand_io_oe  = state_q == S_BUS;
  assign nand_cle    = nand_io_oe && cur[8];
  assign nand_ale    = nand_io_oe && !cur[8];
  assign nand_we_n   = !(nand_io_oe && !phase_hi_q);
  assign nand_io_out = nand_io_oe ? {8'h00, cur[7:0]} : 16'h0000;
endmodule

// File: rtl/nand_cmd_seq_chk.sv
module nand_cmd_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        seq_done,
  input logic        wait_start,
  input logic        nand_ce_n,
  input logic        nand_cle,
  input logic        nand_ale,
  input logic        nand_we_n,
  input logic [15:0] nand_io_out
);
  AST_CMD_ADDR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale)); // R1
  AST_BUS_STABLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n && !$past(nand_we_n)) |-> ($stable(nand_io_out) && $stable(nand_cle) && $stable(nand_ale))); // R1
  AST_UPPER_BYTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (nand_cle || nand_ale) |-> (nand_io_out[15:8] == 8'h00)); // R5
  AST_WAIT_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    wait_start |=> !wait_start); // R10
  AST_WAIT_AFTER_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    wait_start |-> (nand_we_n && !nand_cle && !nand_ale && !nand_ce_n)); // R10
  AST_STROBE_UNDER_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> !nand_ce_n); // R11
  AST_DONE_RELEASES_CE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> (nand_ce_n && !seq_done)); // R11
endmodule

bind nand_cmd_seq nand_cmd_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .seq_done(seq_done), .wait_start(wait_start),
  .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
  .nand_we_n(nand_we_n), .nand_io_out(nand_io_out)
);

// File: tb/nand_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module nand_cmd_seq_tb_top;
  localparam int WH = 2;
  localparam int CHIP_DLY = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [7:0]  req_opcode = '0;
  logic [15:0] req_col = '0;
  logic        req_col_en = 1'b0;
  logic [23:0] req_row = '0;
  logic        req_row_en = 1'b0;
  logic cfg_large_page = 1'b1, cfg_bus16 = 1'b0, cfg_row3 = 1'b0, cfg_has_rb = 1'b1;
  logic [7:0] cfg_tccs_ticks = '0;
  logic wait_done;
  logic busy, seq_done, wait_start, nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_io_oe;
  logic [15:0] nand_io_out;

  always #4 clk = ~clk;

  nand_cmd_seq #(.WE_LOW_TICKS(2), .WE_HIGH_TICKS(WH), .CHIP_DELAY_TICKS(CHIP_DLY)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_opcode(req_opcode),
    .req_col(req_col), .req_col_en(req_col_en), .req_row(req_row), .req_row_en(req_row_en),
    .cfg_large_page(cfg_large_page), .cfg_bus16(cfg_bus16), .cfg_row3(cfg_row3),
    .cfg_has_rb(cfg_has_rb), .cfg_tccs_ticks(cfg_tccs_ticks), .wait_done(wait_done),
    .busy(busy), .seq_done(seq_done), .wait_start(wait_start), .nand_ce_n(nand_ce_n),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
    .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe));

  logic [17:0] exp_q [$];
  string       tag_q [$];
  int n_checks = 0, n_fails = 0, mon_checks = 0, mon_fails = 0;
  int cyc = 0, last_rise = 0, done_gap = 0, done_cnt = 0, ws_cnt = 0;
  logic prev_we = 1'b1;

  // Ready-wait engine model: answers 5 clocks after each request
  initial begin
    wait_done = 1'b0;
    forever begin
      @(negedge clk);
      if (wait_start) begin
        repeat (5) @(negedge clk);
        wait_done = 1'b1;
        @(negedge clk);
        wait_done = 1'b0;
      end
    end
  end

  // Monitor: pops one expected item per WE# rising edge
  always @(negedge clk) begin
    logic [17:0] got, want;
    string t;
    cyc++;
    if (rst_n) begin
      if (!prev_we && nand_we_n) begin
        last_rise = cyc;
        got = {nand_cle, nand_ale, nand_io_out};
        mon_checks++;
        if (exp_q.size() == 0) begin
          mon_fails++;
          $display("FAIL R11 unexpected bus cycle: actual %05h expected none", got);
        end else begin
          want = exp_q.pop_front();
          t = tag_q.pop_front();
          if (got !== want) begin
            mon_fails++;
            $display("FAIL %s bus cycle: actual %05h expected %05h", t, got, want);
          end
        end
      end
      if (wait_start) ws_cnt++;
      if (seq_done) begin
        done_gap = cyc - last_rise;
        done_cnt++;
      end
    end
    prev_we = nand_we_n;
  end

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic cmd(input logic [7:0] b, input string tag);
    exp_q.push_back({2'b10, 8'h00, b});
    tag_q.push_back(tag);
  endtask

  task automatic adr(input logic [7:0] b, input string tag);
    exp_q.push_back({2'b01, 8'h00, b});
    tag_q.push_back(tag);
  endtask

  task automatic run_req(input logic [7:0] op, input logic [15:0] col, input bit col_en,
                         input logic [23:0] row, input bit row_en,
                         input int exp_gap, input int exp_ws, input bit poke, input string tag);
    int ws0, dn0;
    @(negedge clk);
    req_opcode = op; req_col = col; req_col_en = col_en;
    req_row = row; req_row_en = row_en; req_valid = 1'b1;
    ws0 = ws_cnt; dn0 = done_cnt;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 3000 && done_cnt == dn0; k++) begin
      @(negedge clk);
      if (poke && k == 3) begin
        req_opcode = 8'h90; req_col_en = 1'b1; req_valid = 1'b1;
      end else req_valid = 1'b0;
    end
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(done_cnt == dn0 + 1, tag, "done pulses", done_cnt - dn0, 1);
    check(exp_q.size() == 0, tag, "bus cycles left unsent", exp_q.size(), 0);
    check(done_gap == exp_gap, tag, "clocks from last strobe to done", done_gap, exp_gap);
    check(ws_cnt - ws0 == exp_ws, tag, "wait_start pulses", ws_cnt - ws0, exp_ws);
    exp_q.delete();
    tag_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired: actual hung expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks + mon_checks + 1, n_fails + mon_fails + 1);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(nand_ce_n && nand_we_n && !nand_cle && !nand_ale && !nand_io_oe && !busy, "R11",
          "reset idle outputs", {nand_ce_n, nand_we_n, nand_cle, nand_ale, nand_io_oe, busy}, 6'b110000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Large page, 8-bit bus, ready/busy pin present
    cmd(8'h00, "R6"); adr(8'h23, "R1"); adr(8'h01, "R4"); adr(8'h67, "R3"); adr(8'h45, "R3"); cmd(8'h30, "R6");
    run_req(8'h00, 16'h0123, 1, 24'h004567, 1, WH + 6, 1, 0, "R6");

    cmd(8'h00, "R7");
    run_req(8'h00, 16'h0000, 0, 24'h0, 0, WH, 0, 0, "R7");

    cmd(8'h00, "R6"); adr(8'h10, "R6"); adr(8'h08, "R6"); adr(8'h0A, "R3"); adr(8'h00, "R3"); cmd(8'h30, "R6");
    run_req(8'h50, 16'h0010, 1, 24'h00000A, 1, WH + 6, 1, 0, "R6");

    cmd(8'h05, "R8"); adr(8'h00, "R2"); adr(8'h02, "R4"); cmd(8'hE0, "R8");
    run_req(8'h05, 16'h0200, 1, 24'h0, 0, WH + 63, 0, 0, "R8");

    cfg_tccs_ticks = 8'd10;
    cmd(8'h85, "R8"); adr(8'h44, "R8"); adr(8'h00, "R8");
    run_req(8'h85, 16'h0044, 1, 24'h0, 0, WH + 10, 0, 0, "R8");
    cfg_tccs_ticks = 8'd0;

    cmd(8'h90, "R4"); adr(8'h00, "R4");
    run_req(8'h90, 16'h0000, 1, 24'h0, 0, WH, 0, 0, "R4");

    cfg_row3 = 1'b1;
    cmd(8'h60, "R10"); adr(8'h56, "R3"); adr(8'h34, "R3"); adr(8'h12, "R3");
    run_req(8'h60, 16'h0000, 0, 24'h123456, 1, WH, 0, 0, "R3");
    cfg_row3 = 1'b0;

    cmd(8'hD0, "R10");
    run_req(8'hD0, 16'h0000, 0, 24'h0, 0, WH, 0, 0, "R10");

    cfg_bus16 = 1'b1;
    cmd(8'h00, "R5"); adr(8'h23, "R5"); adr(8'h01, "R5"); adr(8'h01, "R5"); adr(8'h00, "R5"); cmd(8'h30, "R5");
    run_req(8'h00, 16'h0246, 1, 24'h000001, 1, WH + 6, 1, 0, "R5");

    cmd(8'hEF, "R5"); adr(8'h90, "R5");
    run_req(8'hEF, 16'h0090, 1, 24'h0, 0, WH, 0, 0, "R5");
    cfg_bus16 = 1'b0;

    cfg_has_rb = 1'b0;
    cmd(8'hFF, "R10");
    run_req(8'hFF, 16'h0000, 0, 24'h0, 0, WH + CHIP_DLY, 0, 0, "R10");
    cfg_has_rb = 1'b1;

    // Small page mode
    cfg_large_page = 1'b0;
    cmd(8'h00, "R9"); cmd(8'h80, "R9"); adr(8'h10, "R9"); adr(8'h07, "R3"); adr(8'h00, "R3");
    run_req(8'h80, 16'h0010, 1, 24'h000007, 1, WH, 0, 0, "R9");

    cmd(8'h01, "R9"); cmd(8'h80, "R9"); adr(8'h10, "R9");
    run_req(8'h80, 16'h0110, 1, 24'h0, 0, WH, 0, 0, "R9");

    cmd(8'h50, "R9"); cmd(8'h80, "R9"); adr(8'h05, "R9");
    run_req(8'h80, 16'h0205, 1, 24'h0, 0, WH, 0, 0, "R9");

    cmd(8'h00, "R9"); cmd(8'h80, "R9"); adr(8'h02, "R2"); adr(8'h00, "R2");
    run_req(8'h80, 16'h0300, 0, 24'h000002, 1, WH, 0, 0, "R9");

    cmd(8'h00, "R4"); adr(8'h20, "R4"); adr(8'h03, "R1"); adr(8'h00, "R1");
    run_req(8'h00, 16'h0020, 1, 24'h000003, 1, WH + 6, 1, 0, "R1");

    // Request during busy must be dropped
    cmd(8'h70, "R11");
    run_req(8'h70, 16'h0000, 0, 24'h0, 0, WH, 0, 1, "R11");
    repeat (20) @(negedge clk);
    check(!busy && nand_ce_n, "R11", "idle after ignored request", busy, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_checks + mon_checks, n_fails + mon_fails);
    $finish;
  end
endmodule